// File: doc/BRIEF.md
# Serial EEPROM Power-On Configuration Loader

This block runs once after every reset. It drives a small I2C master and reads a fixed image from a serial EEPROM. It loads the first eight bytes into configuration output registers. It checks those eight bytes against a stored check byte, and it captures the next eight bytes into an identity register file. No software takes part in the load. A single `load_done` output tells the rest of the chip that the configuration outputs are final.

The identity bytes are six identifier bytes followed by two check bytes. The block does not validate them. A local-bus read port serves them back, so the block replaces a small identity ROM on that bus. Reads made before the load has finished, and reads whose address falls outside the identity window, return all ones.

A device that fails to acknowledge ends the load early. In that case the status output reports that no usable EEPROM is present, and the configuration outputs keep their reset values.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While reset is held, and directly after it: `load_done`, `cks_err` and `no_eeprom` are 0, `cfg_data` equals `CFG_DEFAULT`, `scl_o` is 1 and `sda_oe` is 0 (SDA released).
- R2: The bus sequence is fixed:
  - a start, then the control byte {DEV_ADDR,0} and the word address 0x00;
  - a repeated start, then {DEV_ADDR,1};
  - 17 read bytes, MSB first; the master ACKs each of the first 16 by driving SDA low in the ninth clock, and NACKs the 17th by releasing SDA;
  - a stop.
- R3: Within a byte, successive SCL falling edges are exactly 4*CLK_DIV system clocks apart. During byte transfers, SDA changes only while SCL is low.
- R4: EEPROM byte k (k = 0..7) appears on `cfg_data[8k+7:8k]` and stays there unchanged once `load_done` is 1.
- R5: If the 8-bit sum of EEPROM bytes 0..8 is not zero modulo 256, both `cks_err` and `no_eeprom` become 1. If the sum is zero, both stay 0. The configuration bytes are loaded in either case.
- R6: EEPROM bytes 9..16 are stored as identity bytes 0..7. No flag depends on their values. After `load_done`, a read at address ID_BASE+j returns identity byte j.
- R7: If the device does not ACK any of the three address/control bytes, the master sends a stop and ends the load. `load_done` and `no_eeprom` become 1, `cks_err` stays 0, `cfg_data` keeps `CFG_DEFAULT`, and identity reads return 0xFF.
- R8: A local-bus read returns 0xFF in two cases: `load_done` is 0, or the upper address bits do not match ID_BASE.
- R9: `load_done` stays 1 until the next reset. After it rises, SCL stays high and SDA stays released.
- R10: With LB_REG=1, `lb_rdata` holds the result of a read in the cycle after `lb_rd` is sampled high, and keeps it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_o | output | 1 | I2C clock level driven by the master |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sensed SDA line level |
| cfg_data | output | N_CFG*8 | Loaded configuration bytes, byte k at bits [8k+7:8k] |
| load_done | output | 1 | Load finished or aborted |
| cks_err | output | 1 | Configuration check byte mismatch |
| no_eeprom | output | 1 | No usable EEPROM (mismatch or missing ACK) |
| lb_rd | input | 1 | Local-bus read strobe |
| lb_addr | input | LB_AW | Local-bus read address |
| lb_rdata | output | 8 | Local-bus read data |

## Verification
Some properties are checked on every cycle:
- SDA stays still while SCL is high inside a byte.
- A check-byte error always carries the no-EEPROM flag.
- `load_done` is sticky, and the bus stays idle after it.
- Configuration outputs are frozen after completion.
- An abort with no check-byte error leaves the reset defaults.
- Reads before completion return 0xFF.

Other behaviour can only be shown by the bench's scenarios:
- the exact byte order on the bus and the ACK/NACK pattern of the master;
- the SCL bit period;
- the mapping of EEPROM bytes to output bits and identity addresses;
- the flag results for a good image, a bad check byte, and missing ACKs at different points of the sequence.

// File: rtl/eeld_pkg.sv
package eeld_pkg;

   // Primitive operations of the bit engine
   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_STOP  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } i2c_op_e;

   // Load sequencer states, in bus order
   typedef enum logic [2:0] {
      SQ_START  = 3'd0,
      SQ_CTRLW  = 3'd1,
      SQ_WADDR  = 3'd2,
      SQ_RSTART = 3'd3,
      SQ_CTRLR  = 3'd4,
      SQ_READ   = 3'd5,
      SQ_STOP   = 3'd6,
      SQ_DONE   = 3'd7
   } seq_st_e;

   localparam logic [7:0] BLANK_BYTE = 8'hFF;

endpackage

// File: rtl/eeld_i2c_phy.sv
module eeld_i2c_phy
   import eeld_pkg::*;
#(
   parameter int unsigned CLK_DIV  = 125,
   parameter bit          SDA_SYNC = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  i2c_op_e    cmd_op,
   input  logic [7:0] cmd_wdata,
   input  logic       cmd_mack,
   output logic       cmd_done,
   output logic [7:0] rx_byte,
   output logic       peer_ack,
   output logic       scl_o,
   output logic       sda_oe,
   input  logic       sda_i
);

   localparam int unsigned DIV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [3:0]  ACK_SLOT = 4'd8;

   initial begin
      assert (CLK_DIV >= 2) else $fatal(1, "CLK_DIV must be at least 2");
      assert (!SDA_SYNC || CLK_DIV >= 3) else $fatal(1, "synchronised SDA needs CLK_DIV >= 3");
   end

   logic             busy_q;
   i2c_op_e          op_q;
   logic [7:0]       sh_q;
   logic             mack_q;
   logic [3:0]       bit_q;
   logic [1:0]       ph_q;
   logic [DIV_W-1:0] div_q;
   logic             scl_q;
   logic             oe_q;
   logic             ack_q;
   logic             done_q;
   logic             sda_s;
   logic             tick;
   logic             is_byte;

   // Input path variant: two-stage synchroniser or direct sampling
   generate
      if (SDA_SYNC) begin : g_sync
         logic [1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= 2'b11;
            else        sync_q <= {sync_q[0], sda_i};
         end
         assign sda_s = sync_q[1];
      end else begin : g_direct
         assign sda_s = sda_i;
      end
   endgenerate

   assign tick    = busy_q && (div_q == DIV_W'(CLK_DIV - 1));
   assign is_byte = (op_q == OP_WRITE) || (op_q == OP_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         op_q   <= OP_STOP;
         sh_q   <= '0;
         mack_q <= 1'b0;
         bit_q  <= '0;
         ph_q   <= '0;
         div_q  <= '0;
         scl_q  <= 1'b1;
         oe_q   <= 1'b0;
         ack_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            div_q <= '0;
            if (cmd_valid) begin
               busy_q <= 1'b1;
               op_q   <= cmd_op;
               sh_q   <= cmd_wdata;
               mack_q <= cmd_mack;
               bit_q  <= '0;
               ph_q   <= '0;
            end
         end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
               ph_q <= ph_q + 2'd1;
               unique case (op_q)
                  OP_START: begin
                     unique case (ph_q)
                        2'd0: oe_q  <= 1'b0;
                        2'd1: scl_q <= 1'b1;
                        2'd2: oe_q  <= 1'b1;
                        2'd3: scl_q <= 1'b0;
                     endcase
                  end
                  OP_STOP: begin
                     unique case (ph_q)
                        2'd0: oe_q  <= 1'b1;
                        2'd1: scl_q <= 1'b1;
                        2'd2: oe_q  <= 1'b0;
                        2'd3: oe_q  <= 1'b0;
                     endcase
                  end
                  OP_WRITE, OP_READ: begin
                     unique case (ph_q)
                        2'd0: begin
                           if (bit_q == ACK_SLOT)
                              oe_q <= (op_q == OP_READ) ? mack_q : 1'b0;
                           else
                              oe_q <= (op_q == OP_WRITE) ? ~sh_q[7] : 1'b0;
                        end
                        2'd1: scl_q <= 1'b1;
                        2'd2: begin
                           if (bit_q == ACK_SLOT)
                              ack_q <= ~sda_s;
                           else if (op_q == OP_READ)
                              sh_q <= {sh_q[6:0], sda_s};
                        end
                        2'd3: begin
                           scl_q <= 1'b0;
                           if (op_q == OP_WRITE && bit_q != ACK_SLOT)
                              sh_q <= {sh_q[6:0], 1'b0};
                        end
                     endcase
                  end
               endcase
               if (ph_q == 2'd3) begin
                  if (is_byte && bit_q != ACK_SLOT) begin
                     bit_q <= bit_q + 4'd1;
                  end else begin
                     busy_q <= 1'b0;
                     done_q <= 1'b1;
                  end
               end
            end
         end
      end
   end

   assign cmd_done = done_q;
   assign rx_byte  = sh_q;
   assign peer_ack = ack_q;
   assign scl_o    = scl_q;
   assign sda_oe   = oe_q;

   // R3: inside a byte transfer SDA never moves while SCL stays high
   p_sda_quiet_scl_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && is_byte && scl_q && $past(scl_q) |-> $stable(oe_q));

   // A completion strobe lasts exactly one cycle
   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> !cmd_done);

endmodule

// File: rtl/eeld_seq.sv
module eeld_seq
   import eeld_pkg::*;
#(
   parameter int unsigned N_CFG    = 8,
   parameter int unsigned N_ID     = 8,
   parameter logic [6:0]  DEV_ADDR = 7'h50,
   parameter int unsigned IDX_W    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             cmd_valid,
   output i2c_op_e          cmd_op,
   output logic [7:0]       cmd_wdata,
   output logic             cmd_mack,
   input  logic             cmd_done,
   input  logic [7:0]       rx_byte,
   input  logic             peer_ack,
   output logic             byte_we,
   output logic [IDX_W-1:0] byte_idx,
   output logic [7:0]       byte_val,
   output logic             load_done,
   output logic             cks_err,
   output logic             no_eeprom
);

   localparam int unsigned    N_READ   = N_CFG + 1 + N_ID;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_READ - 1);
   localparam logic [IDX_W-1:0] CKS_IDX  = IDX_W'(N_CFG);

   initial begin
      assert (N_READ <= (1 << IDX_W)) else $fatal(1, "IDX_W too narrow for the image");
   end

   seq_st_e          st_q;
   logic             pend_q;
   logic [IDX_W-1:0] cnt_q;
   logic [7:0]       sum_q;
   logic             done_q;
   logic             cks_q;
   logic             noe_q;
   logic [7:0]       sum_next;

   assign sum_next = sum_q + rx_byte;

   always_comb begin
      cmd_valid = !pend_q && (st_q != SQ_DONE);
      cmd_mack  = (cnt_q != LAST_IDX);
      cmd_wdata = 8'h00;
      cmd_op    = OP_STOP;
      unique case (st_q)
         SQ_START, SQ_RSTART: cmd_op = OP_START;
         SQ_CTRLW: begin
            cmd_op    = OP_WRITE;
            cmd_wdata = {DEV_ADDR, 1'b0};
         end
         SQ_WADDR: begin
            cmd_op    = OP_WRITE;
            cmd_wdata = 8'h00;
         end
         SQ_CTRLR: begin
            cmd_op    = OP_WRITE;
            cmd_wdata = {DEV_ADDR, 1'b1};
         end
         SQ_READ:  cmd_op = OP_READ;
         SQ_STOP, SQ_DONE: cmd_op = OP_STOP;
      endcase
   end

   assign byte_we  = cmd_done && (st_q == SQ_READ);
   assign byte_idx = cnt_q;
   assign byte_val = rx_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_START;
         pend_q <= 1'b0;
         cnt_q  <= '0;
         sum_q  <= '0;
         done_q <= 1'b0;
         cks_q  <= 1'b0;
         noe_q  <= 1'b0;
      end else begin
         if (cmd_valid) pend_q <= 1'b1;
         if (cmd_done) begin
            pend_q <= 1'b0;
            unique case (st_q)
               SQ_START:  st_q <= SQ_CTRLW;
               SQ_RSTART: st_q <= SQ_CTRLR;
               SQ_CTRLW, SQ_WADDR, SQ_CTRLR: begin
                  if (!peer_ack) begin
                     noe_q <= 1'b1;
                     st_q  <= SQ_STOP;
                  end else if (st_q == SQ_CTRLW) begin
                     st_q <= SQ_WADDR;
                  end else if (st_q == SQ_WADDR) begin
                     st_q <= SQ_RSTART;
                  end else begin
                     st_q <= SQ_READ;
                  end
               end
               SQ_READ: begin
                  if (cnt_q < CKS_IDX) sum_q <= sum_next;
                  if (cnt_q == CKS_IDX && sum_next != 8'h00) begin
                     cks_q <= 1'b1;
                     noe_q <= 1'b1;
                  end
                  if (cnt_q == LAST_IDX) st_q <= SQ_STOP;
                  else                   cnt_q <= cnt_q + 1'b1;
               end
               SQ_STOP: begin
                  st_q   <= SQ_DONE;
                  done_q <= 1'b1;
               end
               SQ_DONE: st_q <= SQ_DONE;
            endcase
         end
      end
   end

   assign load_done = done_q;
   assign cks_err   = cks_q;
   assign no_eeprom = noe_q;

   // R5: a check-byte mismatch always reports the device as unusable
   p_cks_implies_noeep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cks_err |-> no_eeprom);

   // R9: completion is sticky until reset
   p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> load_done);

   // R9: no bus command is issued once the load is finished
   p_no_cmd_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> !cmd_valid);

endmodule

// File: rtl/eeld_store.sv
module eeld_store
   import eeld_pkg::*;
#(
   parameter int unsigned         N_CFG       = 8,
   parameter int unsigned         N_ID        = 8,
   parameter int unsigned         IDX_W       = 5,
   parameter logic [N_CFG*8-1:0]  CFG_DEFAULT = '0,
   parameter int unsigned         LB_AW       = 8,
   parameter logic [LB_AW-1:0]    ID_BASE     = '0,
   parameter bit                  LB_REG      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               byte_we,
   input  logic [IDX_W-1:0]   byte_idx,
   input  logic [7:0]         byte_val,
   input  logic               load_done,
   input  logic               lb_rd,
   input  logic [LB_AW-1:0]   lb_addr,
   output logic [N_CFG*8-1:0] cfg_data,
   output logic [7:0]         lb_rdata
);

   localparam int unsigned ID_AW  = (N_ID > 1) ? $clog2(N_ID) : 1;
   localparam int unsigned ID_OFS = N_CFG + 1;

   initial begin
      assert ((1 << ID_AW) == N_ID) else $fatal(1, "N_ID must be a power of two");
      assert (LB_AW > ID_AW) else $fatal(1, "LB_AW must exceed the identity index width");
      assert (ID_BASE[ID_AW-1:0] == '0) else $fatal(1, "ID_BASE must be aligned to N_ID");
   end

   logic [N_ID*8-1:0] id_flat;
   logic              hit;
   logic [ID_AW-1:0]  sel;
   logic [7:0]        rd_c;

   generate
      for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= CFG_DEFAULT[8*g +: 8];
            else if (byte_we && byte_idx == IDX_W'(g))
               q <= byte_val;
         end
         assign cfg_data[8*g +: 8] = q;
      end

      for (genvar g = 0; g < N_ID; g++) begin : g_id
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= BLANK_BYTE;
            else if (byte_we && byte_idx == IDX_W'(ID_OFS + g))
               q <= byte_val;
         end
         assign id_flat[8*g +: 8] = q;
      end
   endgenerate

   assign hit  = (lb_addr[LB_AW-1:ID_AW] == ID_BASE[LB_AW-1:ID_AW]);
   assign sel  = lb_addr[ID_AW-1:0];
   assign rd_c = (hit && load_done) ? id_flat[8*sel +: 8] : BLANK_BYTE;

   generate
      if (LB_REG) begin : g_rd_reg
         logic [7:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_q <= BLANK_BYTE;
            else if (lb_rd) rd_q <= rd_c;
         end
         assign lb_rdata = rd_q;

         // R8: a read issued before completion yields the blank pattern
         p_blank_before_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
            lb_rd && !load_done |=> lb_rdata == BLANK_BYTE);
      end else begin : g_rd_comb
         assign lb_rdata = rd_c;

         // R8: before completion the read port shows the blank pattern
         p_blank_before_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !load_done |-> lb_rdata == BLANK_BYTE);
      end
   endgenerate

   // R4: loaded configuration does not move after completion
   p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_done && $past(load_done) |-> $stable(cfg_data));

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
   import eeld_pkg::*;
#(
   parameter int unsigned        CLK_DIV     = 125,
   parameter bit                 SDA_SYNC    = 1'b1,
   parameter logic [6:0]         DEV_ADDR    = 7'h50,
   parameter int unsigned        N_CFG       = 8,
   parameter int unsigned        N_ID        = 8,
   parameter logic [N_CFG*8-1:0] CFG_DEFAULT = '0,
   parameter int unsigned        LB_AW       = 8,
   parameter logic [LB_AW-1:0]   ID_BASE     = 8'h40,
   parameter bit                 LB_REG      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic               scl_o,
   output logic               sda_oe,
   input  logic               sda_i,
   output logic [N_CFG*8-1:0] cfg_data,
   output logic               load_done,
   output logic               cks_err,
   output logic               no_eeprom,
   input  logic               lb_rd,
   input  logic [LB_AW-1:0]   lb_addr,
   output logic [7:0]         lb_rdata
);

   localparam int unsigned N_READ = N_CFG + 1 + N_ID;
   localparam int unsigned IDX_W  = $clog2(N_READ);

   logic             cmd_valid;
   i2c_op_e          cmd_op;
   logic [7:0]       cmd_wdata;
   logic             cmd_mack;
   logic             cmd_done;
   logic [7:0]       rx_byte;
   logic             peer_ack;
   logic             byte_we;
   logic [IDX_W-1:0] byte_idx;
   logic [7:0]       byte_val;

   eeld_i2c_phy #(
      .CLK_DIV  (CLK_DIV),
      .SDA_SYNC (SDA_SYNC)
   ) i_phy (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_wdata (cmd_wdata),
      .cmd_mack  (cmd_mack),
      .cmd_done  (cmd_done),
      .rx_byte   (rx_byte),
      .peer_ack  (peer_ack),
      .scl_o     (scl_o),
      .sda_oe    (sda_oe),
      .sda_i     (sda_i)
   );

   eeld_seq #(
      .N_CFG    (N_CFG),
      .N_ID     (N_ID),
      .DEV_ADDR (DEV_ADDR),
      .IDX_W    (IDX_W)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_wdata (cmd_wdata),
      .cmd_mack  (cmd_mack),
      .cmd_done  (cmd_done),
      .rx_byte   (rx_byte),
      .peer_ack  (peer_ack),
      .byte_we   (byte_we),
      .byte_idx  (byte_idx),
      .byte_val  (byte_val),
      .load_done (load_done),
      .cks_err   (cks_err),
      .no_eeprom (no_eeprom)
   );

   eeld_store #(
      .N_CFG       (N_CFG),
      .N_ID        (N_ID),
      .IDX_W       (IDX_W),
      .CFG_DEFAULT (CFG_DEFAULT),
      .LB_AW       (LB_AW),
      .ID_BASE     (ID_BASE),
      .LB_REG      (LB_REG)
   ) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_we   (byte_we),
      .byte_idx  (byte_idx),
      .byte_val  (byte_val),
      .load_done (load_done),
      .lb_rd     (lb_rd),
      .lb_addr   (lb_addr),
      .cfg_data  (cfg_data),
      .lb_rdata  (lb_rdata)
   );

   // R9: a finished loader leaves the bus idle
   p_bus_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> scl_o && !sda_oe);

   // R7: an abort without a check-byte error keeps the reset configuration
   p_abort_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load_done && no_eeprom && !cks_err |-> cfg_data == CFG_DEFAULT);

endmodule

// File: tb/test_eeprom_cfg_loader.sv
`timescale 1ns/1ps
module test_eeprom_cfg_loader;

   localparam int unsigned CLK_DIV = 4;
   localparam logic [6:0]  DEV     = 7'h50;
   localparam logic [63:0] CFG_DEF = 64'h0123_4567_89AB_CDEF;
   localparam logic [7:0]  IDB     = 8'h40;
   localparam int          NBYTES  = 17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lb_rd = 1'b0;
   logic [7:0]  lb_addr = 8'h00;
   logic        slv_low = 1'b0;
   logic        scl_o, sda_oe, sda_line;
   logic [63:0] cfg_data;
   logic        load_done, cks_err, no_eeprom;
   logic [7:0]  lb_rdata;

   int          n_chk = 0;
   int          n_err = 0;
   int          nack_at = -1;
   logic [7:0]  mem [NBYTES];
   logic [7:0]  exp_q [$];
   logic        ack_q [$];

   always #2.5 clk = ~clk;

   assign sda_line = ~(sda_oe | slv_low);

   eeprom_cfg_loader #(
      .CLK_DIV     (CLK_DIV),
      .DEV_ADDR    (DEV),
      .CFG_DEFAULT (CFG_DEF),
      .ID_BASE     (IDB)
   ) i_eeprom_cfg_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_o     (scl_o),
      .sda_oe    (sda_oe),
      .sda_i     (sda_line),
      .cfg_data  (cfg_data),
      .load_done (load_done),
      .cks_err   (cks_err),
      .no_eeprom (no_eeprom),
      .lb_rd     (lb_rd),
      .lb_addr   (lb_addr),
      .lb_rdata  (lb_rdata)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // ---------------- EEPROM model (monitor side of the scoreboard) -----------
   task automatic slv_rx(output logic [7:0] b);
      b = 8'h00;
      for (int i = 0; i < 8; i++) begin
         @(posedge scl_o);
         b = {b[6:0], sda_line};
      end
      @(negedge scl_o);
   endtask

   task automatic slv_ack(input logic give);
      slv_low = give;
      @(negedge scl_o);
      slv_low = 1'b0;
   endtask

   task automatic slv_tx(input logic [7:0] d, input bit measure, output logic mack);
      realtime t0;
      t0 = 0.0;
      for (int b = 7; b >= 0; b--) begin
         slv_low = ~d[b];
         @(negedge scl_o);
         if (measure && b == 6) t0 = $realtime;
         if (measure && b == 5)
            chk("R3 scl bit period ns", 64'(int'($realtime - t0)), 64'(4 * CLK_DIV * 5));
      end
      slv_low = 1'b0;
      @(posedge scl_o);
      mack = ~sda_line;
      @(negedge scl_o);
   endtask

   task automatic score_byte(input int pos, input logic [7:0] got);
      if (exp_q.size() == 0) begin
         chk("R2 unexpected bus byte", 64'(got), 64'hXX);
      end else begin
         logic [7:0] e;
         e = exp_q.pop_front();
         chk($sformatf("R2 address byte %0d", pos), 64'(got), 64'(e));
      end
   endtask

   initial begin : slave
      logic [7:0] b;
      logic       m;
      forever begin
         @(negedge sda_line iff scl_o === 1'b1);
         @(negedge scl_o);
         slv_rx(b);
         score_byte(0, b);
         if (nack_at == 0) begin slv_ack(1'b0); @(posedge sda_line iff scl_o === 1'b1); continue; end
         slv_ack(1'b1);
         slv_rx(b);
         score_byte(1, b);
         if (nack_at == 1) begin slv_ack(1'b0); @(posedge sda_line iff scl_o === 1'b1); continue; end
         slv_ack(1'b1);
         @(negedge sda_line iff scl_o === 1'b1);
         @(negedge scl_o);
         slv_rx(b);
         score_byte(2, b);
         if (nack_at == 2) begin slv_ack(1'b0); @(posedge sda_line iff scl_o === 1'b1); continue; end
         slv_ack(1'b1);
         for (int i = 0; i < NBYTES; i++) begin
            slv_tx(mem[i], i == 3, m);
            if (ack_q.size() == 0) chk("R2 unexpected read byte", 64'(m), 64'hX);
            else chk($sformatf("R2 master ack after byte %0d", i), 64'(m), 64'(ack_q.pop_front()));
         end
         @(posedge sda_line iff scl_o === 1'b1);
      end
   end

   // ---------------- driver side -----------------
   task automatic expect_load(input int nk);
      exp_q.delete();
      ack_q.delete();
      exp_q.push_back({DEV, 1'b0});
      if (nk != 0) exp_q.push_back(8'h00);
      if (nk != 0 && nk != 1) exp_q.push_back({DEV, 1'b1});
      if (nk < 0) begin
         for (int i = 0; i < NBYTES; i++) ack_q.push_back(i != NBYTES - 1);
      end
   endtask

   task automatic fill_image(input bit good);
      logic [7:0] s;
      s = 8'h00;
      for (int i = 0; i < 8; i++) begin
         mem[i] = 8'h3C ^ 8'(i * 37);
         s = s + mem[i];
      end
      mem[8] = good ? (8'h00 - s) : (8'h01 - s);
      for (int i = 9; i < NBYTES; i++) mem[i] = 8'hA0 + 8'(i * 3);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic lb_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      lb_rd = 1'b1;
      lb_addr = a;
      @(negedge clk);
      lb_rd = 1'b0;
      d = lb_rdata;
   endtask

   task automatic wait_done();
      while (load_done !== 1'b1) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [63:0] image_cfg();
      logic [63:0] v;
      for (int i = 0; i < 8; i++) v[8*i +: 8] = mem[i];
      return v;
   endfunction

   initial begin : main
      logic [7:0] d;
      fill_image(1'b1);
      expect_load(-1);
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1 load_done", 64'(load_done), 64'd0);
      chk("R1 cks_err", 64'(cks_err), 64'd0);
      chk("R1 no_eeprom", 64'(no_eeprom), 64'd0);
      chk("R1 cfg default", cfg_data, CFG_DEF);
      chk("R1 scl released", 64'(scl_o), 64'd1);
      chk("R1 sda released", 64'(sda_oe), 64'd0);
      rst_n = 1'b1;
      // R8: read during the load
      lb_read(IDB + 8'd2, d);
      chk("R8 read before done", 64'(d), 64'hFF);
      wait_done();
      // Good image
      chk("R4 cfg bytes", cfg_data, image_cfg());
      chk("R5 cks_err good", 64'(cks_err), 64'd0);
      chk("R5 no_eeprom good", 64'(no_eeprom), 64'd0);
      chk("R2 all address bytes seen", 64'(exp_q.size()), 64'd0);
      chk("R2 all read bytes seen", 64'(ack_q.size()), 64'd0);
      for (int j = 0; j < 8; j++) begin
         lb_read(IDB + 8'(j), d);
         chk($sformatf("R6 identity byte %0d", j), 64'(d), 64'(mem[9+j]));
      end
      lb_read(8'h48, d);
      chk("R8 outside window", 64'(d), 64'hFF);
      lb_read(8'h00, d);
      chk("R8 low address outside window", 64'(d), 64'hFF);
      lb_read(IDB + 8'd5, d);
      @(negedge clk);
      chk("R10 data held after read", 64'(lb_rdata), 64'(mem[14]));
      repeat (200) @(negedge clk);
      chk("R9 done sticky", 64'(load_done), 64'd1);
      chk("R9 scl idle", 64'(scl_o), 64'd1);
      chk("R9 sda idle", 64'(sda_oe), 64'd0);
      chk("R4 cfg held", cfg_data, image_cfg());

      // Bad check byte
      fill_image(1'b0);
      expect_load(-1);
      do_reset();
      wait_done();
      chk("R5 cks_err bad", 64'(cks_err), 64'd1);
      chk("R5 no_eeprom bad", 64'(no_eeprom), 64'd1);
      chk("R5 cfg still loaded", cfg_data, image_cfg());
      lb_read(IDB + 8'd7, d);
      chk("R6 identity after bad check", 64'(d), 64'(mem[16]));

      // Missing ACK at each address/control byte
      for (int k = 0; k < 3; k++) begin
         fill_image(1'b1);
         nack_at = k;
         expect_load(k);
         do_reset();
         wait_done();
         chk($sformatf("R7 no_eeprom nack %0d", k), 64'(no_eeprom), 64'd1);
         chk($sformatf("R7 cks_err nack %0d", k), 64'(cks_err), 64'd0);
         chk($sformatf("R7 cfg default nack %0d", k), cfg_data, CFG_DEF);
         chk($sformatf("R7 bytes seen nack %0d", k), 64'(exp_q.size()), 64'd0);
         lb_read(IDB, d);
         chk($sformatf("R7 identity blank nack %0d", k), 64'(d), 64'hFF);
         chk($sformatf("R9 bus idle nack %0d", k), 64'({scl_o, sda_oe}), 64'b10);
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R9 watchdog: actual run still busy expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule